// File: doc/BRIEF.md
# Packet Back-Trace Buffer

This is a passive debug monitor for the output port of a network node. It watches the outgoing packet interface and does not drive it. Each time a packet starts to leave the node, it writes one record into a small circular store. The record holds the packet's destination and source identifiers and the number of clock cycles since the previous departure. Once the store is full, each new departure replaces the oldest record, so the store always holds the last `DEPTH` departures.

Debug logic or a test harness can stop recording with a freeze input and then read the history back. The read port is indexed and combinational, and it counts backwards in time: index 0 is the newest record. Each read also returns a valid flag, which is low for indices that have not been filled since reset. The depth and all field widths are parameters.

Top module: `pkt_trace_buf`

## Requirements
- R1: A record is written on every clock edge where `pkt_valid`, `pkt_ready` and `pkt_sop` are all high and `freeze` is low. That record is readable at index 0 right after the same edge.
- R2: A record is presented as `rd_entry = {dst, src, gap}`. The destination sits in the most significant `DST_W` bits, the source in the next `SRC_W` bits, and the interval in the least significant `GAP_W` bits.
- R3: Index k returns the record written k captures before the newest one.
- R4: After more than `DEPTH` captures, only the newest `DEPTH` records are kept. The oldest record is overwritten first.
- R5: The interval field holds the number of clock edges strictly between this capture and the previous one, so back-to-back captures give 0. For the first capture it counts from reset release. It saturates at 2^`GAP_W`-1.
- R6: While `freeze` is high, start-of-packet beats are not recorded and the stored records do not change. The interval count keeps running from the last real capture.
- R7: After reset no record is valid. `rd_valid` is high only for indices below the number of records written since reset.
- R8: Beats with `pkt_sop` low, and beats with `pkt_ready` low, write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pkt_valid | input | 1 | Output port beat valid |
| pkt_ready | input | 1 | Output port beat accepted by the link |
| pkt_sop | input | 1 | Beat is the header of a packet |
| pkt_dst | input | DST_W | Destination identifier from the header beat |
| pkt_src | input | SRC_W | Source identifier from the header beat |
| freeze | input | 1 | Stop recording and hold the history |
| rd_idx | input | $clog2(DEPTH) | Age of the record to read, 0 = newest |
| rd_entry | output | DST_W+SRC_W+GAP_W | Selected record {dst, src, gap} |
| rd_valid | output | 1 | Selected index holds a record |

## Verification
A broken write pointer shows up at the ports on the first read after the next capture: index 0 returns an older or stale record. A broken fill count shows up as a `rd_valid` that is wrong for the index at the boundary of the filled region. A fault in the interval counter appears in the low field of the very next record, and it is easiest to see with back-to-back packets and after long idle stretches. Reading every index after each stimulus group pins down both the ordering and the slot where the ring wraps.

// File: rtl/pkt_trace_pkg.sv
package pkt_trace_pkg;
    localparam int unsigned DEF_DEPTH = 8;
    localparam int unsigned DEF_DST_W = 4;
    localparam int unsigned DEF_SRC_W = 4;
    localparam int unsigned DEF_GAP_W = 8;

    // Slot holding the record written 'age' captures before the newest one.
    function automatic int unsigned age_to_slot(int unsigned wr_ptr, int unsigned age,
                                                int unsigned depth);
        return (wr_ptr + 2 * depth - 1 - age) % depth;
    endfunction
endpackage

// File: rtl/trace_gap_counter.sv
module trace_gap_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] gap
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } gap_state_t;

    gap_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart) begin
            s_d.cnt = '0;
        end else if (s_q.cnt != MAX) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign gap = s_q.cnt;

    // R5: once saturated, the count holds until the next capture
    p_gap_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == MAX && !restart) |=> (s_q.cnt == MAX));
endmodule

// File: rtl/trace_ring_store.sv
module trace_ring_store #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned ENT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ENT_W-1:0]         wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [ENT_W-1:0]         rd_data,
    output logic                     rd_valid
);
    import pkt_trace_pkg::*;

    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][ENT_W-1:0] mem;
        logic [PTR_W-1:0]            ptr;
        logic [CNT_W-1:0]            fill;
    } ring_state_t;

    ring_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.mem[s_q.ptr] = wr_data;
            s_d.ptr          = (s_q.ptr == LAST) ? '0 : s_q.ptr + 1'b1;
            if (s_q.fill != FULL) s_d.fill = s_q.fill + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic [PTR_W-1:0] slot;

    always_comb begin
        slot     = PTR_W'(age_to_slot(int'(s_q.ptr), int'(rd_idx), DEPTH));
        rd_valid = (CNT_W + 1)'(rd_idx) < (CNT_W + 1)'(s_q.fill);
        rd_data  = rd_valid ? s_q.mem[slot] : '0;
    end

    // R4: the fill count never exceeds the depth
    p_fill_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fill <= FULL);
    // R7: records never disappear once written
    p_fill_mono_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fill >= $past(s_q.fill));
    // R6: without a write the history is unchanged
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(s_q.ptr) && $stable(s_q.fill) && $stable(s_q.mem)));
endmodule

// File: rtl/pkt_trace_buf.sv
module pkt_trace_buf #(
    parameter int unsigned DEPTH = pkt_trace_pkg::DEF_DEPTH,
    parameter int unsigned DST_W = pkt_trace_pkg::DEF_DST_W,
    parameter int unsigned SRC_W = pkt_trace_pkg::DEF_SRC_W,
    parameter int unsigned GAP_W = pkt_trace_pkg::DEF_GAP_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           pkt_valid,
    input  logic                           pkt_ready,
    input  logic                           pkt_sop,
    input  logic [DST_W-1:0]               pkt_dst,
    input  logic [SRC_W-1:0]               pkt_src,
    input  logic                           freeze,
    input  logic [$clog2(DEPTH)-1:0]       rd_idx,
    output logic [DST_W+SRC_W+GAP_W-1:0]   rd_entry,
    output logic                           rd_valid
);
    localparam int unsigned ENT_W = DST_W + SRC_W + GAP_W;

    logic             capture;
    logic [GAP_W-1:0] gap;
    logic [ENT_W-1:0] new_entry;

    always_comb begin
        capture   = pkt_valid && pkt_ready && pkt_sop && !freeze;
        new_entry = {pkt_dst, pkt_src, gap};
    end

    trace_gap_counter #(.W(GAP_W)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (capture),
        .gap     (gap)
    );

    trace_ring_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (capture),
        .wr_data  (new_entry),
        .rd_idx   (rd_idx),
        .rd_data  (rd_entry),
        .rd_valid (rd_valid)
    );

    // R1: a capture makes the newest record readable
    p_newest_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && rd_idx == '0) |=> rd_valid);
endmodule

// File: tb/pkt_trace_buf_bench.sv
`timescale 1ns/100ps
module pkt_trace_buf_bench;
    localparam int DEPTH = 8;
    localparam int DST_W = 4;
    localparam int SRC_W = 4;
    localparam int GAP_W = 8;
    localparam int ENT_W = DST_W + SRC_W + GAP_W;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int GMAX  = (1 << GAP_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_valid = 1'b0, pkt_ready = 1'b0, pkt_sop = 1'b0, freeze = 1'b0;
    logic [DST_W-1:0] pkt_dst = '0;
    logic [SRC_W-1:0] pkt_src = '0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [ENT_W-1:0] rd_entry;
    logic             rd_valid;

    int checks = 0;
    int errors = 0;
    int gap_m = 0;
    logic [ENT_W-1:0] exp_q[$];

    always #5 clk = ~clk;

    pkt_trace_buf #(.DEPTH(DEPTH), .DST_W(DST_W), .SRC_W(SRC_W), .GAP_W(GAP_W)) u_pkt_trace_buf (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_sop(pkt_sop), .pkt_dst(pkt_dst), .pkt_src(pkt_src), .freeze(freeze),
        .rd_idx(rd_idx), .rd_entry(rd_entry), .rd_valid(rd_valid)
    );

    // Driver: called just after a falling edge, returns just after the next one.
    task automatic step(input logic v, input logic r, input logic s,
                        input logic [DST_W-1:0] d, input logic [SRC_W-1:0] sr, input logic f);
        pkt_valid = v; pkt_ready = r; pkt_sop = s; pkt_dst = d; pkt_src = sr; freeze = f;
        @(posedge clk);
        if (v && r && s && !f) begin
            exp_q.push_front({d, sr, GAP_W'(gap_m)});
            if (exp_q.size() > DEPTH) void'(exp_q.pop_back());
            gap_m = 0;
        end else if (gap_m != GMAX) begin
            gap_m++;
        end
        @(negedge clk);
        pkt_valid = 1'b0; pkt_sop = 1'b0; freeze = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0, '0, '0, 1'b0);
    endtask

    task automatic send(input logic [DST_W-1:0] d, input logic [SRC_W-1:0] sr);
        step(1'b1, 1'b1, 1'b1, d, sr, 1'b0);
    endtask

    // Monitor: compares every index against the expected queue during the low phase.
    task automatic check_all(input string tag);
        for (int k = 0; k < DEPTH; k++) begin
            logic             ev;
            logic [ENT_W-1:0] ee;
            rd_idx = IDX_W'(k);
            #0.5;
            ev = (k < exp_q.size());
            ee = ev ? exp_q[k] : '0;
            checks++;
            if (rd_valid !== ev || (ev && rd_entry !== ee)) begin
                errors++;
                $display("FAIL %s idx %0d: valid %b entry %h, expected valid %b entry %h",
                         tag, k, rd_valid, rd_entry, ev, ee);
            end
        end
        rd_idx = '0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: nothing valid while in reset
        check_all("R7 reset");
        rst_n = 1'b1;
        gap_m = 0;

        // R1, R5: first capture counts from reset release
        send(4'h3, 4'h5);
        checks++;
        rd_idx = '0; #0.5;
        if (rd_valid !== 1'b1 || rd_entry !== {4'h3, 4'h5, 8'd0}) begin
            errors++;
            $display("FAIL R1: valid %b entry %h, expected 1 %h", rd_valid, rd_entry, {4'h3, 4'h5, 8'd0});
        end
        idle(4);
        send(4'hA, 4'h1);
        idle(1);
        send(4'h6, 4'h9);
        // R2: field placement of the newest record
        rd_idx = '0; #0.5;
        checks++;
        if (rd_entry[ENT_W-1 -: DST_W] !== 4'h6 || rd_entry[GAP_W +: SRC_W] !== 4'h9
            || rd_entry[GAP_W-1:0] !== 8'd1) begin
            errors++;
            $display("FAIL R2: entry %h, expected %h", rd_entry, {4'h6, 4'h9, 8'd1});
        end
        check_all("R3 order");

        // R8: non-header beats and stalled headers are ignored
        step(1'b1, 1'b1, 1'b0, 4'hF, 4'hF, 1'b0);
        step(1'b1, 1'b0, 1'b1, 4'hE, 4'hE, 1'b0);
        check_all("R8 ignore");

        // R6: frozen header is not recorded; gap keeps counting
        step(1'b1, 1'b1, 1'b1, 4'hD, 4'hD, 1'b1);
        check_all("R6 freeze");
        send(4'h2, 4'h7);
        check_all("R6 gap after freeze");

        // R5: back-to-back captures give zero
        send(4'h1, 4'h1);
        send(4'h2, 4'h2);
        check_all("R5 back-to-back");

        // R4: wrap and overwrite
        for (int i = 0; i < 10; i++) begin
            send(DST_W'(i), SRC_W'(15 - i));
            if (i % 3 == 0) idle(i);
        end
        check_all("R4 overwrite");

        // R5: saturation after a long idle stretch
        idle(300);
        send(4'hC, 4'h4);
        check_all("R5 saturate");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule